// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block detects a stalled processor. Software services it by toggling a
service line; each level change on that line, rising or falling, restarts an
internal counter that advances once per timebase tick. If the line holds one
level for the whole timeout window, the block emits a single-cycle expiry
pulse that the surrounding supervisor turns into a system reset.

The service line is asynchronous and passes through a synchroniser that runs
at the system clock. Edge detection also runs at the system clock, so a
service pulse only one clock wide is still seen. While the supervisor holds
its reset, the counter stays at zero. It starts counting once that reset is
released. When the service pin is flagged as floating, software servicing is
ignored. An internal self-service then restarts the counter at half the
window, so the timer never expires in that state.

Top module: `edge_wdog_top`

## Requirements
- R1: While block reset `rst_n` is low, and in the first cycle after it is released, `expire` is 0.
- R2: With no clear in between, `expire` is 1 for exactly one clock cycle. That cycle follows the clock edge at which the counter registers the TIMEOUT_TICKS-th tick since the last clear.
- R3: A rising or a falling change of `svc_in` clears the counter. The change is seen after the two-stage synchroniser, so the clear takes effect at the third rising clock edge after the change.
- R4: A `svc_in` high pulse one clock cycle wide is detected and clears the counter.
- R5: While `sup_rst` is 1, the counter is held at zero, ticks are not counted and `expire` stays 0.
- R6: Counting starts with the first tick sampled after `sup_rst` returns to 0.
- R7: After an expiry, no further expiry occurs until `sup_rst` has been asserted.
- R8: While `svc_float` is 1, changes on `svc_in` are ignored. A tick that arrives when the counter is at TIMEOUT_TICKS/2 − 1 or above clears the counter instead of advancing it, so `expire` never fires.
- R9: After block reset the first synchronised sample only primes the edge detector. A `svc_in` held at 1 through reset therefore does not count as an edge.
- R10: A clear and a tick in the same cycle leave the counter at zero; the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block reset, active low, asynchronous |
| svc_in | input | 1 | Asynchronous service line from software |
| svc_float | input | 1 | Service pin flagged as floating; selects self-service (synchronous) |
| sup_rst | input | 1 | Supervisor reset is asserted (synchronous) |
| tick | input | 1 | One-cycle timebase strobe |
| expire | output | 1 | One-cycle timeout pulse |

## Verification
The assertions assume that `sup_rst`, `svc_float` and `tick` are synchronous to `clk`, and that `tick` is a strobe rather than a level held high. Only `svc_in` may change at any time. The stimulus drives every input on the falling clock edge and produces `tick` as a single-cycle strobe every third cycle. It changes `svc_float` and `sup_rst` only between those strobes. Service toggles are placed either at random points or on a cycle chosen so that the clear meets a tick.

// File: rtl/edge_wdog_pkg.sv
package edge_wdog_pkg;

  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_EDGE = 2'd1,
    CLR_SELF = 2'd2,
    CLR_SUP  = 2'd3
  } clr_src_e;

  // counter bits needed to hold 0 .. limit-1
  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  // count at which the internal self-service acts
  function automatic int self_point(input int limit);
    return (limit / 2 < 1) ? 1 : limit / 2;
  endfunction

endpackage

// File: rtl/edge_wdog_sync.sv
module edge_wdog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out,
  output logic q_valid
);
  logic [STAGES-1:0] dat_q;
  logic [STAGES-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q[0] <= 1'b0;
      vld_q[0] <= 1'b0;
    end else begin
      dat_q[0] <= d_in;
      vld_q[0] <= 1'b1;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_q[g] <= 1'b0;
        vld_q[g] <= 1'b0;
      end else begin
        dat_q[g] <= dat_q[g-1];
        vld_q[g] <= vld_q[g-1];
      end
    end
  end

  assign q_out   = dat_q[STAGES-1];
  assign q_valid = vld_q[STAGES-1];
endmodule

// File: rtl/edge_wdog_edge.sv
module edge_wdog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic smp_vld,
  input  logic float_i,
  output logic edge_o
);
  logic prev_q;
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else if (smp_vld) begin
      prev_q   <= smp;
      primed_q <= 1'b1;
    end
  end

  // a floating pin carries no meaningful transitions
  assign edge_o = primed_q & (smp ^ prev_q) & ~float_i;
endmodule

// File: rtl/edge_wdog_self.sv
module edge_wdog_self #(
  parameter int LIMIT = 16,
  parameter int CW    = 4,
  parameter int HALF  = 8
) (
  input  logic          float_i,
  input  logic          tick_i,
  input  logic          done_i,
  input  logic [CW-1:0] cnt_i,
  output logic          self_o
);
  localparam logic [CW-1:0] SELF_AT = CW'(HALF - 1);

  // stands in for the pulse a floating pin receives from the counter chain
  assign self_o = float_i & tick_i & ~done_i & (cnt_i >= SELF_AT);
endmodule

// File: rtl/edge_wdog_count.sv
module edge_wdog_count
  import edge_wdog_pkg::*;
#(
  parameter int LIMIT = 16,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  clr_src_e      src_i,
  output logic [CW-1:0] cnt_o,
  output logic          done_o,
  output logic          hit_o,
  output logic          expire_o
);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          exp_q;

  assign hit_o = (src_i == CLR_NONE) & tick_i & ~done_q & (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      exp_q <= hit_o;
      unique case (src_i)
        CLR_SUP: begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end
        CLR_EDGE, CLR_SELF: cnt_q <= '0;
        default: begin
          if (hit_o) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else if (tick_i && !done_q) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cnt_o    = cnt_q;
  assign done_o   = done_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/edge_wdog_top.sv
module edge_wdog_top
  import edge_wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic svc_in,
  input  logic svc_float,
  input  logic sup_rst,
  input  logic tick,
  output logic expire
);
  localparam int CW   = cnt_bits(TIMEOUT_TICKS);
  localparam int HALF = self_point(TIMEOUT_TICKS);

  logic          svc_s_w;
  logic          svc_vld_w;
  logic          svc_edge_w;
  logic          self_w;
  logic          done_w;
  logic          hit_w;
  logic [CW-1:0] cnt_w;
  clr_src_e      src_w;

  edge_wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(svc_in),
    .q_out(svc_s_w), .q_valid(svc_vld_w)
  );

  edge_wdog_edge u_edge (
    .clk(clk), .rst_n(rst_n), .smp(svc_s_w), .smp_vld(svc_vld_w),
    .float_i(svc_float), .edge_o(svc_edge_w)
  );

  edge_wdog_self #(.LIMIT(TIMEOUT_TICKS), .CW(CW), .HALF(HALF)) u_self (
    .float_i(svc_float), .tick_i(tick), .done_i(done_w),
    .cnt_i(cnt_w), .self_o(self_w)
  );

  always_comb begin
    if (sup_rst)         src_w = CLR_SUP;
    else if (svc_edge_w) src_w = CLR_EDGE;
    else if (self_w)     src_w = CLR_SELF;
    else                 src_w = CLR_NONE;
  end

  edge_wdog_count #(.LIMIT(TIMEOUT_TICKS), .CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .src_i(src_w),
    .cnt_o(cnt_w), .done_o(done_w), .hit_o(hit_w), .expire_o(expire)
  );
endmodule

// File: rtl/edge_wdog_chk.sv
module edge_wdog_chk #(
  parameter int LIMIT = 16,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sup_rst,
  input logic          svc_float,
  input logic          expire,
  input logic          svc_edge,
  input logic          done,
  input logic [CW-1:0] cnt
);
  // R2: expiry is a single-cycle pulse
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  // R2: counter never passes the last count
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));

  // R3: a detected service edge leaves the counter at zero
  assert_edge_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_edge |=> (cnt == '0));

  // R5: supervisor reset holds the counter and silences expiry
  assert_sup_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst |=> (cnt == '0 && !expire));

  // R7: no second pulse while the expired state persists
  assert_no_rerun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> !expire);

  // R8: self-service keeps the timer from firing
  assert_float_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(svc_float) |-> !expire);
endmodule

bind edge_wdog_top edge_wdog_chk #(.LIMIT(TIMEOUT_TICKS), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .svc_float(svc_float),
  .expire(expire), .svc_edge(svc_edge_w), .done(done_w), .cnt(cnt_w)
);

// File: tb/edge_wdog_tb.sv
module edge_wdog_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 16;
  localparam int HALF       = T / 2;
  localparam int TICK_DIV   = 3;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic svc_in = 1'b0;
  logic svc_float = 1'b0;
  logic sup_rst = 1'b0;
  logic tick = 1'b0;
  logic expire;

  int n_checks = 0;
  int n_fail = 0;
  int n_exp = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit finished = 0;

  edge_wdog_top #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .svc_in(svc_in), .svc_float(svc_float),
    .sup_rst(sup_rst), .tick(tick), .expire(expire)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // timebase strobe, one cycle in TICK_DIV
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % TICK_DIV;
    tick <= (tdiv == 0);
  end

  // behavioural reference
  bit sq[$];
  int fill, m_cnt;
  bit primed, prev, m_done, m_exp, s_now, edge_now, self_now;

  always @(posedge clk) begin
    if (!rst_n) begin
      sq = '{1'b0, 1'b0};
      fill = 0; primed = 0; prev = 0;
      m_cnt = 0; m_done = 0; m_exp = 0;
    end else begin
      s_now = sq[1];
      edge_now = primed && (s_now != prev) && !svc_float;
      self_now = svc_float && tick && !m_done && (m_cnt >= HALF - 1);
      m_exp = 0;
      if (sup_rst) begin
        m_cnt = 0; m_done = 0;
      end else if (edge_now || self_now) begin
        m_cnt = 0;
      end else if (tick && !m_done) begin
        if (m_cnt == T - 1) begin
          m_exp = 1; m_done = 1; m_cnt = 0;
        end else begin
          m_cnt++;
        end
      end
      if (fill >= 2) begin prev = s_now; primed = 1; end
      if (fill < 2) fill++;
      void'(sq.pop_back());
      sq.push_front(svc_in);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!finished) begin
      check(cur_req, int'(expire), int'(m_exp));
      if (expire) n_exp++;
    end
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sup_pulse();
    sup_rst = 1'b1; wait_cyc(4); sup_rst = 1'b0;
  endtask

  initial begin
    // R9: service line held high through block reset
    svc_in = 1'b1;
    wait_cyc(5);
    check("R1", int'(expire), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(expire), 0);
    cur_req = "R9";
    n_exp = 0;
    wait_cyc(70);
    check("R9", n_exp, 1);

    cur_req = "R7";
    wait_cyc(150);
    check("R7", n_exp, 1);

    // R5: held in supervisor reset
    cur_req = "R5";
    sup_rst = 1'b1; n_exp = 0;
    wait_cyc(200);
    check("R5", n_exp, 0);

    // R6: release, count from zero
    cur_req = "R6";
    sup_rst = 1'b0;
    wait_cyc(40);
    check("R6", n_exp, 0);
    wait_cyc(20);
    check("R6", n_exp, 1);

    // R3: toggling both directions
    cur_req = "R3";
    sup_pulse(); n_exp = 0;
    for (int i = 0; i < 12; i++) begin
      wait_cyc(25 + (i % 4) * 3);
      svc_in = ~svc_in;
    end
    check("R3", n_exp, 0);

    // R4: one-cycle pulses
    cur_req = "R4";
    svc_in = 1'b0;
    sup_pulse(); n_exp = 0;
    for (int i = 0; i < 10; i++) begin
      wait_cyc(30);
      svc_in = 1'b1; @(negedge clk); svc_in = 1'b0;
    end
    check("R4", n_exp, 0);

    // R10: clears timed to land on a tick
    cur_req = "R10";
    sup_pulse(); n_exp = 0;
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 13; k++) begin
        @(negedge clk);
        while (tick !== 1'b1) @(negedge clk);
      end
      @(negedge clk);
      svc_in = ~svc_in;
    end
    check("R10", n_exp, 0);

    // R8: floating pin, external toggles ignored
    cur_req = "R8";
    sup_pulse(); n_exp = 0;
    @(negedge clk);
    while (tick !== 1'b1) @(negedge clk);
    svc_float = 1'b1;
    for (int i = 0; i < 6; i++) begin
      wait_cyc(80);
      svc_in = ~svc_in;
    end
    wait_cyc(100);
    check("R8", n_exp, 0);
    @(negedge clk);
    while (tick !== 1'b1) @(negedge clk);
    svc_float = 1'b0;
    cur_req = "R2";
    wait_cyc(80);
    check("R2", n_exp, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule